// File: doc/BRIEF.md
# Low-Side Current Sampling Window Controller

This block sits between the PWM generator and the gate outputs of a synchronous buck converter. It carries the low-side and high-side gate requests through a register stage. While the low-side gate is on, it opens a sampling window for the over-current comparator. The window opens only after a blanking interval has passed since the gate turned on, so that switching ringing cannot trip it. The window stays open until the gate turns off. The first comparator trip inside a window produces a one-cycle over-current event, and only one event is allowed per switching period.

At high duty the natural low-side pulse can be too short to contain a valid sample, or the PWM may not produce one at all. The block counts switching periods in which no low-side pulse reached the minimum sampling width. Once the count reaches the limit, the next period is forced:
- A low-side pulse that starts in the forced period is held on until it reaches the minimum width.
- If the forced period has no pulse at all, a minimum-width pulse is inserted at the tick that closes that period.

Any extra low-side time is taken from the high-side gate, which is held off whenever the low side is on. All widths are parameters counted in system clock cycles, and the switching period is marked by a one-cycle tick input.

Top module: `lowsideWindowCtl`

## Requirements
- R1: With no forcing active, `lowGate` equals `loReq` delayed by one clock, so each pulse keeps its requested width.
- R2: `hiGate` equals `hiReq` delayed by one clock, except that it is 0 in any cycle in which `lowGate` is 1. The two gates are never 1 together.
- R3: At each `periodTick`, the period that just ended counts as narrow if no low-side pulse reached `MIN_CYC` cycles of on-time during it, and as wide otherwise. A wide period clears the narrow count. A pulse that reaches `MIN_CYC` after a tick counts toward the new period.
- R4: After `NARROW_LIMIT-1` consecutive narrow periods (default 2), a low-side pulse that begins in the next period is held on for exactly `MIN_CYC` cycles if its request is shorter than that. Reaching `MIN_CYC` clears the count.
- R5: If that forced period contains no low-side pulse, a pulse of exactly `MIN_CYC` cycles starts on `lowGate` one clock after the `periodTick` that closes the period.
- R6: A pulse of `MIN_CYC-1` cycles counts as narrow. A pulse of exactly `MIN_CYC` cycles counts as wide.
- R7: The comparator is ignored during the first `BLANK_CYC` cycles in which `lowGate` is 1. It is sampled from the cycle after those on, for as long as `lowGate` stays 1.
- R8: The comparator is ignored while `lowGate` is 0.
- R9: A sampled trip raises `ocpEvent` for exactly one cycle, one clock after the sample. `ocpEvent` is raised at most once between two ticks.
- R10: While `rstN` is 0, `lowGate`, `hiGate` and `ocpEvent` are 0, and the narrow count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodTick | input | 1 | One-cycle pulse at the start of each switching period |
| loReq | input | 1 | Raw low-side gate request from the PWM generator |
| hiReq | input | 1 | Raw high-side gate request from the PWM generator |
| ocpRaw | input | 1 | Comparator: switch node below the current limit while the low side conducts |
| lowGate | output | 1 | Adjusted low-side gate |
| hiGate | output | 1 | Adjusted high-side gate |
| ocpEvent | output | 1 | One-cycle over-current event |

## Verification
The hardest case to reach from the ports is the forced period with no low-side request at all. Reaching it takes two earlier periods whose pulses are both short or missing. The pulse in the period before those two must also have reached its minimum width before that period's tick; a stretched pulse that spills across the tick counts toward the next period instead. The stimulus table walks a fixed sequence of periods that first builds the narrow count with short pulses, then with missing pulses. It then checks that the inserted pulse appears right after the closing tick and holds the high side off. Boundary widths of `MIN_CYC-1` and `MIN_CYC` follow, and the directed comparator tests then place single-cycle trips on the last blanked cycle and on the first open cycle of the window.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic insertStart;  // begin an inserted minimum-width pulse
    logic holdLow;      // current period is forced: hold low side to minimum
    logic periodStart;  // switching period boundary
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lowNext;      // low gate value for the next cycle
    logic lowRise;      // low gate turns on at the next edge
    logic wideHit;      // current pulse reaches the minimum width at the next edge
  } dpStatus_t;

endpackage

// File: rtl/lswDatapath.sv
module lswDatapath
  import lsw_pkg::*;
#(
  parameter int BLANK_CYC = 20,
  parameter int MIN_CYC   = 43
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loReq,
  input  logic       hiReq,
  input  logic       ocpRaw,
  input  ctlStrobe_t ctl,
  output dpStatus_t  stat,
  output logic       lowGate,
  output logic       hiGate,
  output logic       ocpEvent
);

  localparam int WID_W = $clog2(MIN_CYC + 1);
  localparam logic [WID_W-1:0] MIN_V   = WID_W'(MIN_CYC);
  localparam logic [WID_W-1:0] MINM1_V = WID_W'(MIN_CYC - 1);
  localparam logic [WID_W-1:0] BLANK_V = WID_W'(BLANK_CYC);
  localparam logic [WID_W-1:0] ONE_V   = WID_W'(1);

  logic [WID_W-1:0] widthCnt;
  logic [WID_W-1:0] widthNext;
  logic             lowNext;
  logic             stretch;
  logic             windowOpen;
  logic             fire;
  logic             ocpDone;

  // stretch only while forced and short of the minimum
  assign stretch = lowGate & ctl.holdLow & (widthCnt < MIN_V);
  assign lowNext = loReq | ctl.insertStart | stretch;

  always_comb begin
    if (!lowNext)
      widthNext = '0;
    else if (!lowGate)
      widthNext = ONE_V;
    else if (widthCnt == MIN_V)
      widthNext = MIN_V;
    else
      widthNext = widthCnt + ONE_V;
  end

  assign stat.lowNext = lowNext;
  assign stat.lowRise = lowNext & ~lowGate;
  assign stat.wideHit = lowGate & lowNext & (widthCnt == MINM1_V);

  // sampling window opens after the blanking cycles
  assign windowOpen = lowGate & (widthCnt > BLANK_V);
  assign fire       = windowOpen & ocpRaw & ~ocpDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
      lowGate  <= 1'b0;
      hiGate   <= 1'b0;
      ocpEvent <= 1'b0;
      ocpDone  <= 1'b0;
    end else begin
      widthCnt <= widthNext;
      lowGate  <= lowNext;
      hiGate   <= hiReq & ~lowNext;
      ocpEvent <= fire;
      ocpDone  <= ctl.periodStart ? fire : (ocpDone | fire);
    end
  end

endmodule

// File: rtl/lswControl.sv
module lswControl
  import lsw_pkg::*;
#(
  parameter int NARROW_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       periodTick,
  input  dpStatus_t  stat,
  output ctlStrobe_t ctl
);

  localparam int CNT_W = $clog2(NARROW_LIMIT + 1);
  localparam logic [CNT_W-1:0] ARM_AT  = CNT_W'(NARROW_LIMIT - 2);
  localparam logic [CNT_W-1:0] ARMED_V = CNT_W'(NARROW_LIMIT - 1);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  logic [CNT_W-1:0] narrowCnt, narrowNext;
  logic             armed, armedNext;
  logic             pulseSeen, seenNext;
  logic             wideSeen, wideNext;

  assign ctl.periodStart = periodTick;
  assign ctl.holdLow     = armed;
  assign ctl.insertStart = periodTick & armed & ~pulseSeen;

  always_comb begin
    narrowNext = narrowCnt;
    armedNext  = armed;
    seenNext   = pulseSeen | stat.lowRise;
    wideNext   = wideSeen | stat.wideHit;
    if (periodTick) begin
      // a pulse in flight belongs to the new period
      seenNext = stat.lowNext;
      wideNext = stat.wideHit;
      if (!armed) begin
        if (wideSeen) begin
          narrowNext = '0;
        end else if (narrowCnt == ARM_AT) begin
          narrowNext = ARMED_V;
          armedNext  = 1'b1;
        end else begin
          narrowNext = narrowCnt + ONE_V;
        end
      end
    end
    if (armed && stat.wideHit) begin
      armedNext  = 1'b0;
      narrowNext = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      narrowCnt <= '0;
      armed     <= 1'b0;
      pulseSeen <= 1'b0;
      wideSeen  <= 1'b0;
    end else begin
      narrowCnt <= narrowNext;
      armed     <= armedNext;
      pulseSeen <= seenNext;
      wideSeen  <= wideNext;
    end
  end

endmodule

// File: rtl/lowsideWindowCtl.sv
module lowsideWindowCtl
  import lsw_pkg::*;
#(
  parameter int BLANK_CYC    = 20,
  parameter int MIN_CYC      = 43,
  parameter int NARROW_LIMIT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic periodTick,
  input  logic loReq,
  input  logic hiReq,
  input  logic ocpRaw,
  output logic lowGate,
  output logic hiGate,
  output logic ocpEvent
);

  ctlStrobe_t ctl;
  dpStatus_t  stat;

  lswControl #(.NARROW_LIMIT(NARROW_LIMIT)) uCtl (
    .clk(clk), .rstN(rstN), .periodTick(periodTick), .stat(stat), .ctl(ctl)
  );

  lswDatapath #(.BLANK_CYC(BLANK_CYC), .MIN_CYC(MIN_CYC)) uDp (
    .clk(clk), .rstN(rstN), .loReq(loReq), .hiReq(hiReq), .ocpRaw(ocpRaw),
    .ctl(ctl), .stat(stat), .lowGate(lowGate), .hiGate(hiGate), .ocpEvent(ocpEvent)
  );

endmodule

// File: rtl/lowsideWindowChk.sv
module lowsideWindowChk #(
  parameter int BLANK_CYC    = 20,
  parameter int MIN_CYC      = 43,
  parameter int NARROW_LIMIT = 3
) (
  input logic clk,
  input logic rstN,
  input logic periodTick,
  input logic hiReq,
  input logic ocpRaw,
  input logic lowGate,
  input logic hiGate,
  input logic ocpEvent
);

  localparam int RUN_W = $clog2(MIN_CYC + 1);
  localparam int SC_W  = $clog2(NARROW_LIMIT + 2);

  // cycles lowGate has been on, up to the previous cycle
  logic [RUN_W-1:0] runQ;
  logic [SC_W-1:0]  shortCnt;
  logic             wideInPer;
  logic             thisWide;

  assign thisWide = lowGate & (runQ == RUN_W'(MIN_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ      <= '0;
      shortCnt  <= '0;
      wideInPer <= 1'b0;
    end else begin
      if (!lowGate)
        runQ <= '0;
      else if (runQ != RUN_W'(MIN_CYC))
        runQ <= runQ + RUN_W'(1);
      if (periodTick) begin
        wideInPer <= 1'b0;
        if (wideInPer || thisWide)
          shortCnt <= '0;
        else if (shortCnt != '1)
          shortCnt <= shortCnt + SC_W'(1);
      end else if (thisWide) begin
        wideInPer <= 1'b1;
      end
    end
  end

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(hiGate && lowGate));

  assert_hi_from_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    hiGate |-> $past(hiReq));

  assert_single_event_R9: assert property (@(posedge clk) disable iff (!rstN)
    ocpEvent |=> !ocpEvent);

  assert_blanking_R7: assert property (@(posedge clk) disable iff (!rstN)
    ocpEvent |-> (runQ > RUN_W'(BLANK_CYC)));

  assert_gate_on_sample_R8: assert property (@(posedge clk) disable iff (!rstN)
    ocpEvent |-> ($past(lowGate) && $past(ocpRaw)));

  assert_forced_period_R4: assert property (@(posedge clk) disable iff (!rstN)
    shortCnt <= SC_W'(NARROW_LIMIT));

endmodule

bind lowsideWindowCtl lowsideWindowChk #(
  .BLANK_CYC(BLANK_CYC), .MIN_CYC(MIN_CYC), .NARROW_LIMIT(NARROW_LIMIT)
) uChk (
  .clk(clk), .rstN(rstN), .periodTick(periodTick), .hiReq(hiReq),
  .ocpRaw(ocpRaw), .lowGate(lowGate), .hiGate(hiGate), .ocpEvent(ocpEvent)
);

// File: tb/sim_lowsideWindowCtl.sv
`timescale 1ns/1ps
module sim_lowsideWindowCtl;

  localparam int BLANK = 20;
  localparam int MINW  = 43;
  localparam int PER   = 100;
  localparam int NV    = 18;
  // requested low width per period, expected gate pulse (0 = none), requirement
  localparam int VW[NV] = '{60, 10, 10, 10, 50, 0, 0, 0, 20, 20, 20, 20, 42, 43, 42, 42, 42, 60};
  localparam int VE[NV] = '{60, 10, 10, 43, 50, 0, 0, 43, 20, 20, 20, 43, 42, 43, 42, 42, 43, 60};
  localparam int VT[NV] = '{1, 1, 3, 4, 1, 5, 5, 5, 3, 1, 3, 4, 3, 6, 6, 6, 4, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic periodTick = 1'b0, loReq = 1'b0, hiReq = 1'b0, ocpRaw = 1'b0;
  logic lowGate, hiGate, ocpEvent;

  int checks = 0, failures = 0;
  int pulseQ[$];
  int run = 0, overlapCnt = 0, evCnt = 0, evRun = 0, evRunMax = 0;
  logic hiAt10 [NV];
  logic hiAt40 [NV];
  logic evAt61, evAt62;
  bit done = 0;

  always #5 clk = ~clk;

  lowsideWindowCtl #(.BLANK_CYC(BLANK), .MIN_CYC(MINW), .NARROW_LIMIT(3)) u0 (
    .clk(clk), .rstN(rstN), .periodTick(periodTick), .loReq(loReq), .hiReq(hiReq),
    .ocpRaw(ocpRaw), .lowGate(lowGate), .hiGate(hiGate), .ocpEvent(ocpEvent)
  );

  // monitor: low pulse widths, overlap, events
  always @(negedge clk) begin
    if (rstN) begin
      if (lowGate) run++;
      else if (run > 0) begin pulseQ.push_back(run); run = 0; end
      if (lowGate && hiGate) overlapCnt++;
      if (ocpEvent) begin evCnt++; evRun++; if (evRun > evRunMax) evRunMax = evRun; end
      else evRun = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input int t);
    case (t)
      1: return "R1";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  // one switching period; sample outputs first, then drive
  task automatic runPeriod(input int w, input int idx, input int ocpS, input int ocpL);
    for (int c = 0; c < PER; c++) begin
      @(negedge clk);
      if (idx >= 0 && c == 10) hiAt10[idx] = hiGate;
      if (idx >= 0 && c == 40) hiAt40[idx] = hiGate;
      if (c == 61) evAt61 = ocpEvent;
      if (c == 62) evAt62 = ocpEvent;
      periodTick = (c == 0);
      loReq  = (w > 0) && (c >= PER - w);
      hiReq  = (c >= 1) && (c < PER - w - 2);
      ocpRaw = (c >= ocpS) && (c < ocpS + ocpL);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e0;
    repeat (4) @(negedge clk);
    check("R10", lowGate, 0, "lowGate in reset");
    check("R10", hiGate, 0, "hiGate in reset");
    check("R10", ocpEvent, 0, "ocpEvent in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R10", lowGate, 0, "lowGate after reset");

    // table walk
    for (int i = 0; i < NV; i++) runPeriod(VW[i], i, 0, 0);
    runPeriod(0, -1, 0, 0);
    begin
      int k = 0;
      int expCnt = 0;
      for (int i = 0; i < NV; i++) if (VE[i] != 0) expCnt++;
      check("R5", pulseQ.size(), expCnt, "number of low pulses");
      for (int i = 0; i < NV; i++) begin
        if (VE[i] != 0) begin
          check(tagOf(VT[i]), (k < pulseQ.size()) ? pulseQ[k] : -1, VE[i],
                $sformatf("pulse width of period %0d", i));
          k++;
        end
      end
    end
    check("R2", hiAt10[1], 1, "hiGate in plain period");
    check("R2", hiAt10[4], 0, "hiGate under stretched spill");
    check("R2", hiAt40[4], 1, "hiGate after stretched spill");
    check("R2", hiAt10[8], 0, "hiGate under inserted pulse");
    check("R2", overlapCnt, 0, "cycles with both gates on");

    // comparator window, low pulse on c=41..100
    runPeriod(60, -1, 0, 0);
    e0 = evCnt; runPeriod(60, -1, 41, 20);
    check("R7", evCnt - e0, 0, "events for trips inside blanking");
    e0 = evCnt; runPeriod(60, -1, 61, 1);
    check("R7", evCnt - e0, 1, "events for trip on first open cycle");
    check("R9", evAt61, 0, "ocpEvent in sample cycle");
    check("R9", evAt62, 1, "ocpEvent one cycle after sample");
    e0 = evCnt; runPeriod(60, -1, 61, 35);
    check("R9", evCnt - e0, 1, "events for long trip in one period");
    e0 = evCnt; runPeriod(60, -1, 5, 30);
    check("R8", evCnt - e0, 0, "events for trip with gate off");
    check("R9", evRunMax, 1, "longest ocpEvent run");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule